// File: doc/BRIEF.md
# Serial Peripheral Host Controller with Internal Loopback

This block drives a four-wire serial peripheral bus as its host. Software reaches it through a word-addressed register port with a combinational read path. Outgoing bytes go into a transmit byte FIFO and incoming bytes come back through a receive byte FIFO. A write to the transfer register starts a run of a programmed number of bytes. During a run, a shift engine clocks each byte out on MOSI, most significant bit first, and samples MISO at the middle of every bit. Clock polarity, clock phase and the clock divider are held in a configuration register. The chip-select pins are driven directly from a register inside the block.

An internal loopback switch replaces the MISO pin with the block's own MOSI. With it, software can check the data path in every clock mode without any external wiring. A zero-length request passes through a start state and completes at once. A three-step software reset returns the block to a clean state without a hardware reset. Three sticky interrupt sources, each with its own enable, drive the interrupt outputs. Software can read the FIFO depths from a read-only info register.

Top module: `spih_top`

## Requirements
- R1: After reset, STATUS (addr 2) reads 0x00000001. Its fields are bit 0 idle, bits 15:8 transmit fill level and bits 23:16 receive fill level. INFO (addr 9) reads the transmit depth in bits 7:0 and the receive depth in bits 15:8, which is 0x1010 for 16-entry FIFOs.
- R2: CS (addr 5, bits NCS-1:0) resets to all ones, drives cs_n_o directly and reads back as written.
- R3: Each write to TXDATA (addr 3, bits 7:0) adds one entry to the transmit FIFO. A write to a full FIFO is dropped, so the level never goes above the depth.
- R4: SCLK rests at CPOL whenever no bit is being shifted. One bit lasts 2*(div+1) system clocks. Bytes leave MSB first. CONFIG (addr 0) holds div in bits 15:0, CPOL in bit 16, CPHA in bit 17 and loopback in bit 18.
- R5: With loopback on, the receive FIFO ends up holding exactly the transmitted bytes in all four CPOL/CPHA modes. Reading RXDATA (addr 4) returns the oldest byte in bits 7:0 and removes it from the FIFO.
- R6: A write to XFER (addr 1) starts a transfer. Its fields are byte count in bits 15:0, transmit enable in bit 16 and receive enable in bit 17. A count of zero returns to idle within a few cycles and sets the complete flag.
- R7: With transmit disabled, MOSI is held at one and the transmit FIFO is not consumed.
- R8: With receive disabled, the received bytes are discarded and the receive level stays at zero.
- R9: Before each byte, the engine waits with SCLK at its resting level while the transmit FIFO is empty (transmit enabled) or the receive FIFO is full (receive enabled). It resumes once the condition clears.
- R10: ISTAT (addr 7) holds three sticky flags. Bit 0 is set on transfer complete, bit 1 while the receive level is at or above its threshold, and bit 2 while the transmit level is at or below its threshold. Writing a one clears a flag, but a condition that is still true sets it again. THRESH (addr 8) holds the receive threshold in bits 7:0 (reset 1) and the transmit threshold in bits 15:8 (reset 0). irq_o equals ISTAT ANDed with IENABLE (addr 6).
- R11: Writing 1 to bit 0 of SRESET (addr 10) clears the transmit FIFO, then returns the engine to idle, then clears the receive FIFO, one step per cycle.
- R12: With loopback off, received bits come from miso_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (removes a byte on RXDATA) |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | NCS | Chip-select lines from the CS register |
| irq_o | output | 3 | Enabled interrupt flags: complete, receive threshold, transmit threshold |

## Verification
The bench builds the block with its default parameters: 16-entry FIFOs, a 16-bit divider and count, and four chip selects. With 16 entries, the full-FIFO drop and the receive-full stall are each reached within a few hundred cycles. Most runs use a divider of zero so that many bytes fit in a short run. One run uses a divider of two so the bench can measure the bit period. The 16-bit count allows a 17-byte request, which forces a stall on a full receive FIFO.

// File: rtl/spih_pkg.sv
package spih_pkg;
  localparam logic [3:0] A_CFG  = 4'd0;
  localparam logic [3:0] A_XFER = 4'd1;
  localparam logic [3:0] A_STAT = 4'd2;
  localparam logic [3:0] A_TXD  = 4'd3;
  localparam logic [3:0] A_RXD  = 4'd4;
  localparam logic [3:0] A_CS   = 4'd5;
  localparam logic [3:0] A_IEN  = 4'd6;
  localparam logic [3:0] A_IST  = 4'd7;
  localparam logic [3:0] A_THR  = 4'd8;
  localparam logic [3:0] A_INFO = 4'd9;
  localparam logic [3:0] A_SRST = 4'd10;

  localparam int unsigned IRQ_N = 3;

  typedef enum logic [1:0] {E_IDLE, E_START, E_WAIT, E_SHIFT} eng_st_t;
  typedef enum logic [1:0] {SR_OFF, SR_TX, SR_ENG, SR_RX} srst_t;

  // Serial clock level: rests at cpol, is active in the second half of a bit
  // for phase 0 and in the first half for phase 1.
  function automatic logic sclk_level(logic cpol, logic cpha, logic active, logic half);
    return cpol ^ (active & (cpha ? ~half : half));
  endfunction

  // Sticky flag update: write-one-to-clear, new events win.
  function automatic logic [IRQ_N-1:0] sticky_next(logic [IRQ_N-1:0] cur,
                                                   logic [IRQ_N-1:0] clr,
                                                   logic [IRQ_N-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/spih_fifo.sv
module spih_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= ptr_inc(wptr);
      if (do_pop)  rptr <= ptr_inc(rptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wptr] <= din;
  end
endmodule

// File: rtl/spih_shift.sv
module spih_shift
  import spih_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic [DIV_W-1:0] div,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             miso,
  input  logic             tx_empty,
  input  logic [7:0]       tx_data,
  input  logic             rx_full,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [7:0]       rx_data,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic             stall
);
  eng_st_t          st;
  logic [CNT_W-1:0] remain;
  logic [DIV_W-1:0] cnt;
  logic             half;
  logic [2:0]       bitn;
  logic [7:0]       txsh, rxsh;
  logic             txen_q, rxen_q;
  logic             tick, byte_go, byte_end;

  assign tick     = (cnt == div);
  assign byte_go  = (st == E_WAIT) && (!txen_q || !tx_empty) && (!rxen_q || !rx_full);
  assign byte_end = (st == E_SHIFT) && tick && half && (bitn == 3'd7);

  assign busy    = (st != E_IDLE);
  assign stall   = (st == E_WAIT) && !byte_go;
  assign done    = ((st == E_START) && (remain == '0)) ||
                   (byte_end && (remain == CNT_W'(1)));
  assign tx_pop  = byte_go && txen_q;
  assign rx_push = byte_end && rxen_q;
  assign rx_data = rxsh;
  assign mosi    = (st == E_SHIFT) ? txsh[7] : 1'b1;
  assign sclk    = sclk_level(cpol, cpha, st == E_SHIFT, half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= E_IDLE;
      remain <= '0;
      cnt    <= '0;
      half   <= 1'b0;
      bitn   <= '0;
      txsh   <= 8'hFF;
      rxsh   <= '0;
      txen_q <= 1'b0;
      rxen_q <= 1'b0;
    end else if (abort) begin
      st   <= E_IDLE;
      cnt  <= '0;
      half <= 1'b0;
      bitn <= '0;
    end else begin
      case (st)
        E_IDLE: if (start) begin
          st     <= E_START;
          remain <= count;
          txen_q <= tx_en;
          rxen_q <= rx_en;
        end
        E_START: st <= (remain == '0) ? E_IDLE : E_WAIT;
        E_WAIT: if (byte_go) begin
          st   <= E_SHIFT;
          txsh <= txen_q ? tx_data : 8'hFF;
          cnt  <= '0;
          half <= 1'b0;
          bitn <= '0;
        end
        E_SHIFT: begin
          if (tick) begin
            cnt <= '0;
            if (!half) begin
              half <= 1'b1;
              rxsh <= {rxsh[6:0], miso};
            end else begin
              half <= 1'b0;
              txsh <= {txsh[6:0], 1'b1};
              bitn <= bitn + 1'b1;
              if (bitn == 3'd7) begin
                remain <= remain - 1'b1;
                st     <= (remain == CNT_W'(1)) ? E_IDLE : E_WAIT;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spih_top.sv
module spih_top
  import spih_pkg::*;
#(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NCS      = 4,
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [3:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic [NCS-1:0]   cs_n_o,
  output logic [IRQ_N-1:0] irq_o
);
  localparam int unsigned TLW    = $clog2(TX_DEPTH + 1);
  localparam int unsigned RLW    = $clog2(RX_DEPTH + 1);
  localparam int unsigned B_CPOL = 16;
  localparam int unsigned B_CPHA = 17;
  localparam int unsigned B_LOOP = 18;
  localparam int unsigned B_TXEN = 16;
  localparam int unsigned B_RXEN = 17;

  logic [DIV_W-1:0] div_q;
  logic             cpol_q, cpha_q, loop_q;
  logic [NCS-1:0]   cs_q;
  logic [IRQ_N-1:0] ien_q, ist_q;
  logic [RLW-1:0]   rx_thr_q;
  logic [TLW-1:0]   tx_thr_q;
  srst_t            sr_q;

  // named internal events
  logic tx_clr, eng_abort, rx_clr;
  logic eng_start, xfer_zero, ist_wr;
  logic tx_push, tx_pop, rx_push, rx_pop;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic [TLW-1:0] tx_level;
  logic [RLW-1:0] rx_level;
  logic [7:0] tx_dout, rx_dout, rx_din;
  logic eng_busy, eng_done, eng_stall, miso_eff, mosi_w;
  logic [IRQ_N-1:0] ist_set;
  logic unused_wbits;

  function automatic logic hit(logic we, logic [3:0] a, logic [3:0] reg_a);
    return we && (a == reg_a);
  endfunction

  assign unused_wbits = ^wdata_i;
  assign tx_clr     = (sr_q == SR_TX);
  assign eng_abort  = (sr_q == SR_ENG);
  assign rx_clr     = (sr_q == SR_RX);
  assign eng_start  = hit(wr_en_i, addr_i, A_XFER) && (sr_q == SR_OFF);
  assign xfer_zero  = (wdata_i[CNT_W-1:0] == '0);
  assign ist_wr     = hit(wr_en_i, addr_i, A_IST);
  assign tx_push    = hit(wr_en_i, addr_i, A_TXD);
  assign rx_pop     = hit(rd_en_i, addr_i, A_RXD);
  assign miso_eff   = loop_q ? mosi_w : miso_i;
  assign mosi_o     = mosi_w;
  assign cs_n_o     = cs_q;
  assign irq_o      = ist_q & ien_q;
  assign ist_set    = {(tx_level <= tx_thr_q), (rx_level >= rx_thr_q), eng_done};

  spih_fifo #(.DEPTH(TX_DEPTH), .W(8)) u_txf (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .din(wdata_i[7:0]),
    .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full), .level(tx_level));

  spih_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rxf (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .din(rx_din),
    .pop(rx_pop), .dout(rx_dout), .empty(rx_empty), .full(rx_full), .level(rx_level));

  spih_shift #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .abort(eng_abort), .start(eng_start),
    .count(wdata_i[CNT_W-1:0]), .tx_en(wdata_i[B_TXEN]), .rx_en(wdata_i[B_RXEN]),
    .div(div_q), .cpol(cpol_q), .cpha(cpha_q), .miso(miso_eff),
    .tx_empty(tx_empty), .tx_data(tx_dout), .rx_full(rx_full),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_din),
    .sclk(sclk_o), .mosi(mosi_w), .busy(eng_busy), .done(eng_done), .stall(eng_stall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      loop_q   <= 1'b0;
      cs_q     <= '1;
      ien_q    <= '0;
      ist_q    <= '0;
      rx_thr_q <= RLW'(1);
      tx_thr_q <= '0;
      sr_q     <= SR_OFF;
    end else begin
      if (hit(wr_en_i, addr_i, A_CFG)) begin
        div_q  <= wdata_i[DIV_W-1:0];
        cpol_q <= wdata_i[B_CPOL];
        cpha_q <= wdata_i[B_CPHA];
        loop_q <= wdata_i[B_LOOP];
      end
      if (hit(wr_en_i, addr_i, A_CS))  cs_q  <= wdata_i[NCS-1:0];
      if (hit(wr_en_i, addr_i, A_IEN)) ien_q <= wdata_i[IRQ_N-1:0];
      if (hit(wr_en_i, addr_i, A_THR)) begin
        rx_thr_q <= wdata_i[RLW-1:0];
        tx_thr_q <= wdata_i[8 +: TLW];
      end
      ist_q <= sticky_next(ist_q, ist_wr ? wdata_i[IRQ_N-1:0] : '0, ist_set);
      case (sr_q)
        SR_OFF:  if (hit(wr_en_i, addr_i, A_SRST) && wdata_i[0]) sr_q <= SR_TX;
        SR_TX:   sr_q <= SR_ENG;
        SR_ENG:  sr_q <= SR_RX;
        default: sr_q <= SR_OFF;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CFG: begin
        rdata_o[DIV_W-1:0] = div_q;
        rdata_o[B_CPOL]    = cpol_q;
        rdata_o[B_CPHA]    = cpha_q;
        rdata_o[B_LOOP]    = loop_q;
      end
      A_STAT: begin
        rdata_o[0]          = !eng_busy && (sr_q == SR_OFF);
        rdata_o[8 +: TLW]   = tx_level;
        rdata_o[16 +: RLW]  = rx_level;
      end
      A_RXD:  rdata_o[7:0]       = rx_dout;
      A_CS:   rdata_o[NCS-1:0]   = cs_q;
      A_IEN:  rdata_o[IRQ_N-1:0] = ien_q;
      A_IST:  rdata_o[IRQ_N-1:0] = ist_q;
      A_THR: begin
        rdata_o[RLW-1:0]  = rx_thr_q;
        rdata_o[8 +: TLW] = tx_thr_q;
      end
      A_INFO: begin
        rdata_o[7:0]  = 8'(TX_DEPTH);
        rdata_o[15:8] = 8'(RX_DEPTH);
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spih_chk.sv
module spih_chk #(
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 16,
  parameter int unsigned TLW      = 5,
  parameter int unsigned RLW      = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sclk,
  input logic           cpol,
  input logic           busy,
  input logic           stall,
  input logic           tx_clr,
  input logic           eng_abort,
  input logic           rx_clr,
  input logic           eng_start,
  input logic           zero_cnt,
  input logic           done,
  input logic [2:0]     ist,
  input logic           ist_wr,
  input logic [TLW-1:0] tx_level,
  input logic [RLW-1:0] rx_level
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= TLW'(TX_DEPTH)) && (rx_level <= RLW'(RX_DEPTH)));

  a_r4_sclk_rest: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol));

  a_r9_stall_rest: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (sclk == cpol));

  a_r6_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && zero_cnt && !busy && !eng_abort) |=> done);

  a_r11_eng_after_tx: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> $past(tx_clr));

  a_r11_rx_after_eng: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |-> $past(eng_abort));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !ist_wr |=> ((ist & $past(ist)) == $past(ist)));
endmodule

bind spih_top spih_chk #(
  .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .TLW(TLW), .RLW(RLW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sclk(sclk_o), .cpol(cpol_q), .busy(eng_busy),
  .stall(eng_stall), .tx_clr(tx_clr), .eng_abort(eng_abort), .rx_clr(rx_clr),
  .eng_start(eng_start), .zero_cnt(xfer_zero), .done(eng_done), .ist(ist_q),
  .ist_wr(ist_wr), .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/spih_top_tb_top.sv
`timescale 1ns/1ps
module spih_top_tb_top;
  localparam logic [3:0] CFG = 0, XFER = 1, STAT = 2, TXD = 3, RXD = 4, CSR = 5,
                         IEN = 6, IST = 7, THR = 8, INFO = 9, SRST = 10;
  localparam logic [31:0] TXEN = 32'h1_0000, RXEN = 32'h2_0000, LOOP = 32'h4_0000;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, miso = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic sclk, mosi;
  logic [3:0] cs_n;
  logic [2:0] irq;
  int checks = 0, errors = 0;
  logic [7:0] mon = 0;
  realtime t_last = 0, t_prev = 0;

  spih_top dut_i (.clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_n_o(cs_n), .irq_o(irq));

  always #10 clk = ~clk;

  always @(posedge sclk) begin
    mon    <= {mon[6:0], mosi};
    t_prev <= t_last;
    t_last <= $realtime;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    int n = 0;
    do begin rd(STAT, s); n++; end while (!s[0] && n < 3000);
    if (!s[0]) chk({tag, " idle"}, {31'd0, s[0]}, 32'd1);
  endtask

  task automatic srst();
    wr(SRST, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(STAT, d); chk("R1 status after reset", d, 32'h1);
    rd(INFO, d); chk("R1 info depths", d, 32'h1010);
    rd(CSR, d);  chk("R2 cs reset value", d, 32'hF);
    chk("R2 cs pins reset", {28'd0, cs_n}, 32'hF);
    rd(IST, d);  chk("R10 only tx-threshold flag after reset", d, 32'h4);
    chk("R10 irq masked after reset", {29'd0, irq}, 32'h0);
    chk("R4 sclk rests low", {31'd0, sclk}, 32'h0);
  endtask

  task automatic t_cs();
    logic [31:0] d;
    wr(CSR, 32'h5);
    chk("R2 cs pins follow register", {28'd0, cs_n}, 32'h5);
    rd(CSR, d); chk("R2 cs readback", d, 32'h5);
  endtask

  task automatic t_fifo_full();
    logic [31:0] d;
    for (int i = 0; i < 17; i++) wr(TXD, i);
    rd(STAT, d); chk("R3 tx level capped at depth", d[15:8], 32'd16);
    wr(XFER, 16 | TXEN);
    wait_idle("R8");
    rd(STAT, d); chk("R8 rx discarded, tx drained", d, 32'h1);
  endtask

  task automatic t_loop(input bit cpol, input bit cpha, input int div);
    logic [31:0] d;
    logic [7:0] b [3];
    b[0] = 8'hA5 ^ {6'd0, cpol, cpha}; b[1] = 8'h3C; b[2] = 8'h81 + {6'd0, cpha, cpol};
    wr(CFG, div | (cpol << 16) | (cpha << 17) | LOOP);
    for (int i = 0; i < 3; i++) wr(TXD, b[i]);
    wr(XFER, 3 | TXEN | RXEN);
    wait_idle("R5");
    chk("R4 sclk at cpol after run", {31'd0, sclk}, {31'd0, cpol});
    for (int i = 0; i < 3; i++) begin
      rd(RXD, d);
      chk($sformatf("R5 loopback mode %0d%0d byte %0d", cpol, cpha, i), d, {24'd0, b[i]});
    end
  endtask

  task automatic t_mosi_msb();
    wr(CFG, 2);
    wr(TXD, 8'hB2);
    wr(XFER, 1 | TXEN);
    wait_idle("R4");
    chk("R4 MSB-first mosi", {24'd0, mon}, 32'hB2);
    chk("R4 bit period 2*(div+1) clocks", int'(t_last - t_prev), 120);
  endtask

  task automatic t_miso();
    logic [31:0] d;
    wr(CFG, 0);
    miso = 1;
    wr(XFER, 2 | RXEN);
    wait_idle("R12");
    rd(RXD, d); chk("R12 miso ones byte 0", d, 32'hFF);
    rd(RXD, d); chk("R12 miso ones byte 1", d, 32'hFF);
    miso = 0;
    wr(XFER, 1 | RXEN);
    wait_idle("R12");
    rd(RXD, d); chk("R12 miso zero byte", d, 32'h0);
  endtask

  task automatic t_txoff();
    logic [31:0] d;
    wr(CFG, LOOP);
    wr(TXD, 8'h12);
    wr(XFER, 2 | RXEN);
    wait_idle("R7");
    rd(STAT, d); chk("R7 tx fifo untouched", d[15:8], 32'd1);
    rd(RXD, d);  chk("R7 mosi ones byte 0", d, 32'hFF);
    rd(RXD, d);  chk("R7 mosi ones byte 1", d, 32'hFF);
    srst();
  endtask

  task automatic t_zero();
    logic [31:0] d;
    wr(IST, 7);
    wr(XFER, TXEN | RXEN);
    repeat (3) @(negedge clk);
    rd(STAT, d); chk("R6 zero count returns idle", d[0], 32'd1);
    rd(IST, d);  chk("R6 zero count complete flag", d[0], 32'd1);
    wr(IST, 1);
    rd(IST, d);  chk("R10 W1C clears complete", d[0], 32'd0);
    chk("R10 true condition re-sets flag", d[2], 32'd1);
    wr(IEN, 1);
    wr(XFER, TXEN);
    repeat (3) @(negedge clk);
    chk("R10 irq follows enabled flags only", {29'd0, irq}, 32'h1);
    wr(IEN, 0);
  endtask

  task automatic t_stall_tx();
    logic [31:0] d;
    wr(CFG, LOOP | (1 << 17));
    wr(TXD, 8'h5A);
    wr(XFER, 2 | TXEN | RXEN);
    repeat (60) @(negedge clk);
    rd(STAT, d); chk("R9 stalled on empty tx", d, 32'h0001_0000);
    chk("R9 sclk rests while stalled", {31'd0, sclk}, 32'd0);
    wr(TXD, 8'hC3);
    wait_idle("R9");
    rd(RXD, d); chk("R9 resumed byte 0", d, 32'h5A);
    rd(RXD, d); chk("R9 resumed byte 1", d, 32'hC3);
  endtask

  task automatic t_stall_rx();
    logic [31:0] d;
    wr(CFG, LOOP | (1 << 16));
    wr(XFER, 17 | RXEN);
    repeat (400) @(negedge clk);
    rd(STAT, d); chk("R9 stalled on full rx", d, 32'h0010_0000);
    chk("R9 sclk rests high while stalled", {31'd0, sclk}, 32'd1);
    rd(RXD, d);
    wait_idle("R9");
    rd(STAT, d); chk("R9 resumed to full rx", d[23:16], 32'd16);
    srst();
    rd(STAT, d); chk("R11 soft reset empties rx", d, 32'h1);
  endtask

  task automatic t_rxthr();
    logic [31:0] d;
    wr(CFG, LOOP);
    wr(THR, 2);
    wr(IST, 7);
    rd(IST, d); chk("R10 rx flag below threshold", d[1], 32'd0);
    wr(TXD, 8'h11); wr(TXD, 8'h22);
    wr(XFER, 2 | TXEN | RXEN);
    wait_idle("R10");
    rd(IST, d); chk("R10 rx threshold flag", d[1], 32'd1);
    srst();
  endtask

  task automatic t_srst();
    logic [31:0] d;
    wr(CFG, LOOP | 3);
    for (int i = 0; i < 3; i++) wr(TXD, 8'h40 + i);
    wr(XFER, 3 | TXEN | RXEN);
    repeat (10) @(negedge clk);
    rd(STAT, d); chk("R11 busy before soft reset", d[0], 32'd0);
    srst();
    rd(STAT, d); chk("R11 soft reset idles and clears", d, 32'h1);
    chk("R11 sclk at rest after soft reset", {31'd0, sclk}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cs();
    t_fifo_full();
    t_loop(0, 0, 0);
    t_loop(0, 1, 0);
    t_loop(1, 0, 1);
    t_loop(1, 1, 0);
    t_mosi_msb();
    t_miso();
    t_txoff();
    t_zero();
    t_stall_tx();
    t_stall_rx();
    t_rxthr();
    t_srst();
    summary();
    $finish;
  end
endmodule